// File: doc/BRIEF.md
# S/PDIF Transmitter with Double-Rate Pair Unpacking

The block turns stereo PCM samples taken from a frame-based serial audio link into a biphase-mark coded serial line of the kind defined by IEC 60958. Each link frame arrives as a set of stereo slot pairs qualified by a one-cycle strobe. A small pair buffer holds the samples until the serializer is ready for them. The serializer builds 32-bit subframes, adds the validity, user, channel-status and parity bits, and shifts them out one biphase cell for each cycle in which the cell-rate enable is high.

At normal rate each link frame provides one stereo pair, taken from the pair picked by the selector. In double-rate mode each link frame provides two pairs. Pair 0 goes out first and the selected pair follows in the next output frame, which doubles the output sample rate for the same link frame rate. Channel status is generated inside the block from the control inputs. The sample-rate field is derived from the rate code and the double-rate flag, so software never writes it. The validity flag can be forced by a control bit or by an input pin, and the line keeps toggling through mute or error periods.

Top module: `spdif_dr_tx`

## Requirements
- R1: Each subframe holds, in transmit order, bit positions 0 to 31: positions 4-7 are 0, the sample occupies positions 8-27 with its MSB at 27 and is sent LSB first, position 29 (user) is 0, and position 31 makes positions 4-31 contain an even number of ones.
- R2: Positions 4-31 use two cells each, with a level change at the start of every bit and a second change mid-bit only for a 1. Positions 0-3 form an 8-cell preamble that is XORed with the level before it; written first cell first, B is 11101000, M is 11100010 and W is 11100100.
- R3: Every frame is a left subframe followed by a right subframe. A block spans CS_LEN frames. Its first left subframe uses B, every other left subframe uses M and every right subframe uses W. After reset the line begins with B and then runs without gaps.
- R4: Position 28 (validity) is 1 whenever the validity control bit is set, the force-invalid input is high, or the rate code is 01. Otherwise it is 0.
- R5: At normal rate a strobed link frame supplies one pair, the one indexed by pair_sel. That pair is sent in one output frame.
- R6: In double-rate mode a strobed link frame supplies pair 0, which is sent first, and then the pair indexed by pair_sel, which is sent in the following output frame.
- R7: An output frame that starts while no pair is waiting carries zero samples in both subframes. The first frame after reset is such a frame.
- R8: A strobe that arrives while pairs are still unsent discards those pairs, loads the new frame and sets overrun. Overrun stays set until ovr_clr is pulsed. No overrun is raised when strobes arrive at the output frame rate.
- R9: Position 30 carries channel-status bit k in frame k of the block, with the same value in both subframes. Bit 0 is pro_use, bit 1 is non_pcm, bit 2 is 0 when copy_flag is set and 1 otherwise, bit 3 is pre_emph, bits 8-14 are category with its LSB at 8, and bit 15 is gen_level. All other bits outside 24-27 are 0.
- R10: Channel-status bits 24-27, listed as {b27,b26,b25,b24}, are 0000 for rate code 00, 0010 for 10 and 0011 for 11. When double rate is on, b27 is also set (1000, 1010, 1011).
- R11: Rate code 01 is reserved. It yields {b27..b24} = 0001 (rate not indicated) in either mode.
- R12: While reset is held, and in the cycle after it is released, spdif_out and overrun are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cell_en | input | 1 | One biphase cell is emitted per cycle in which this is high |
| frame_stb | input | 1 | Link frame valid, one cycle |
| link_pairs | input | NPAIR*2*SAMPLE_W | Pair p left at [2p*W +: W], right at [(2p+1)*W +: W] |
| pair_sel | input | $clog2(NPAIR) | Selected pair index |
| dbl_rate | input | 1 | Double-rate mode enable |
| rate_code | input | 2 | Sample-rate code |
| vld_ctl | input | 1 | Validity control bit |
| force_invalid | input | 1 | Forces validity to 1 |
| non_pcm | input | 1 | Non-PCM flag |
| pro_use | input | 1 | Professional-use flag |
| copy_flag | input | 1 | Copyright asserted |
| pre_emph | input | 1 | 50/15 us pre-emphasis |
| category | input | 7 | Category code |
| gen_level | input | 1 | Generation level |
| ovr_clr | input | 1 | Clears overrun |
| spdif_out | output | 1 | Biphase-mark serial line |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest state to reach is a strobe that arrives while double-rate pairs are still waiting, because normal traffic paced at the output frame rate never causes one. The bench aligns itself on the first B preamble after reset. It then sends two strobes five cycles apart, before the serializer has taken any of the first frame's pairs. It checks that the flag is set and held, that the first frame's pairs never appear on the line, and that the flag clears on request. The sweep over sixteen configurations covers every rate code in both modes, every selector value and several validity sources, and each configuration decodes one full channel-status block from the line.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

  localparam int SUBFRAME_BITS = 32;
  localparam int CELLS_PER_SF  = 2 * SUBFRAME_BITS;
  localparam int PRE_CELLS     = 8;
  localparam int SMP_MSB_POS   = 27;
  localparam int VALID_POS     = 28;
  localparam int CSTAT_POS     = 30;
  localparam int PARITY_POS    = 31;

  typedef enum logic [1:0] {PRE_B, PRE_M, PRE_W} preamble_e;

  // Cell pattern, bit 7 is the first cell in time, relative to a preceding 0.
  function automatic logic [7:0] preamble_cells(preamble_e p);
    case (p)
      PRE_B:   return 8'b1110_1000;
      PRE_M:   return 8'b1110_0010;
      default: return 8'b1110_0100;
    endcase
  endfunction

  // Returns {b27,b26,b25,b24} of channel status.
  function automatic logic [3:0] rate_field(logic dbl, logic [1:0] code);
    case (code)
      2'b00:   return {dbl, 3'b000};
      2'b10:   return {dbl, 3'b010};
      2'b11:   return {dbl, 3'b011};
      default: return 4'b0001;
    endcase
  endfunction

endpackage

// File: rtl/spdif_pair_buf.sv
module spdif_pair_buf #(
  parameter  int SAMPLE_W = 20,
  parameter  int NPAIR    = 4,
  localparam int SEL_W    = (NPAIR > 1) ? $clog2(NPAIR) : 1,
  localparam int PW       = 2 * SAMPLE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  dbl,
  input  logic [SEL_W-1:0]      sel,
  input  logic [NPAIR*PW-1:0]   pair_bus,
  input  logic                  pop,
  input  logic                  ovr_clr,
  output logic [SAMPLE_W-1:0]   head_l,
  output logic [SAMPLE_W-1:0]   head_r,
  output logic                  head_vld,
  output logic                  overrun
);

  logic [PW-1:0] ent0_q, ent0_d, ent1_q, ent1_d;
  logic [PW-1:0] first_p, sel_p;
  logic [1:0]    cnt_q, cnt_d, remain;
  logic          ovr_q, ovr_d;

  always_comb begin
    first_p = pair_bus[0 +: PW];
    sel_p   = pair_bus[int'(sel) * PW +: PW];
    remain  = cnt_q - {1'b0, (pop && cnt_q != 2'd0)};
    ent0_d  = ent0_q;
    ent1_d  = ent1_q;
    cnt_d   = cnt_q;
    ovr_d   = ovr_q & ~ovr_clr;
    if (load) begin
      if (dbl) begin
        ent0_d = first_p;
        ent1_d = sel_p;
        cnt_d  = 2'd2;
      end else begin
        ent0_d = sel_p;
        cnt_d  = 2'd1;
      end
      if (remain != 2'd0) ovr_d = 1'b1;
    end else if (pop && cnt_q != 2'd0) begin
      ent0_d = ent1_q;
      cnt_d  = remain;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent0_q <= '0;
      ent1_q <= '0;
      cnt_q  <= 2'd0;
      ovr_q  <= 1'b0;
    end else begin
      ent0_q <= ent0_d;
      ent1_q <= ent1_d;
      cnt_q  <= cnt_d;
      ovr_q  <= ovr_d;
    end
  end

  assign head_l   = ent0_q[0 +: SAMPLE_W];
  assign head_r   = ent0_q[SAMPLE_W +: SAMPLE_W];
  assign head_vld = (cnt_q != 2'd0);
  assign overrun  = ovr_q;

  // R6
  dbl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && dbl |=> cnt_q == 2'd2);
  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && cnt_q == 2'd2 |=> overrun);
  // R8
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clr |=> overrun);

endmodule

// File: rtl/spdif_cs_gen.sv
module spdif_cs_gen import spdif_tx_pkg::*; #(
  parameter  int CS_LEN = 192,
  localparam int FW     = $clog2(CS_LEN)
) (
  input  logic [FW-1:0] frame_idx,
  input  logic          pro_use,
  input  logic          non_pcm,
  input  logic          copy_flag,
  input  logic          pre_emph,
  input  logic [6:0]    category,
  input  logic          gen_level,
  input  logic          dbl_rate,
  input  logic [1:0]    rate_code,
  output logic          cs_bit
);

  logic [31:0] cs_word;

  always_comb begin
    cs_word        = '0;
    cs_word[0]     = pro_use;
    cs_word[1]     = non_pcm;
    cs_word[2]     = ~copy_flag;
    cs_word[3]     = pre_emph;
    cs_word[14:8]  = category;
    cs_word[15]    = gen_level;
    cs_word[27:24] = rate_field(dbl_rate, rate_code);
    cs_bit         = (int'(frame_idx) < 32) ? cs_word[frame_idx[4:0]] : 1'b0;
  end

endmodule

// File: rtl/spdif_bmc_ser.sv
module spdif_bmc_ser import spdif_tx_pkg::*; #(
  parameter  int SAMPLE_W = 20,
  parameter  int CS_LEN   = 192,
  localparam int FW       = $clog2(CS_LEN),
  localparam int CW       = $clog2(CELLS_PER_SF)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cell_en,
  input  logic [SAMPLE_W-1:0] head_l,
  input  logic [SAMPLE_W-1:0] head_r,
  input  logic                head_vld,
  input  logic                valid_bit,
  input  logic                cs_bit,
  output logic                pop,
  output logic [FW-1:0]       frame_idx,
  output logic                line
);

  logic [CW-1:0]            cell_q, cell_d;
  logic                     right_q, right_d;
  logic [FW-1:0]            frame_q, frame_d;
  logic [SUBFRAME_BITS-1:0] word_q, word_d, word_new;
  logic                     ref_q, ref_d, line_q, line_d;
  logic [SAMPLE_W-1:0]      rsmp_q, rsmp_d, smp_now;
  preamble_e                pre_q, pre_d, pre_now;
  logic [7:0]               pat;
  logic                     par;

  // Subframe assembled at the first cell of each subframe.
  always_comb begin
    smp_now  = right_q ? rsmp_q : (head_vld ? head_l : '0);
    pre_now  = right_q ? PRE_W : ((frame_q == '0) ? PRE_B : PRE_M);
    par      = ^{cs_bit, 1'b0, valid_bit, smp_now};
    word_new = '0;
    word_new[SMP_MSB_POS -: SAMPLE_W] = smp_now;
    word_new[VALID_POS]  = valid_bit;
    word_new[CSTAT_POS]  = cs_bit;
    word_new[PARITY_POS] = par;
  end

  always_comb begin
    cell_d  = cell_q;
    right_d = right_q;
    frame_d = frame_q;
    word_d  = word_q;
    ref_d   = ref_q;
    line_d  = line_q;
    rsmp_d  = rsmp_q;
    pre_d   = pre_q;
    pop     = 1'b0;
    pat     = preamble_cells((cell_q == '0) ? pre_now : pre_q);
    if (cell_en) begin
      if (cell_q == '0) begin
        word_d = word_new;
        pre_d  = pre_now;
        ref_d  = line_q;
        line_d = pat[7] ^ line_q;
        if (!right_q) begin
          pop    = head_vld;
          rsmp_d = head_vld ? head_r : '0;
        end
      end else if (int'(cell_q) < PRE_CELLS) begin
        line_d = pat[3'd7 - cell_q[2:0]] ^ ref_q;
      end else if (!cell_q[0]) begin
        line_d = ~line_q;
      end else begin
        line_d = line_q ^ word_q[cell_q[CW-1:1]];
      end
      if (cell_q == CW'(CELLS_PER_SF - 1)) begin
        cell_d  = '0;
        right_d = ~right_q;
        if (right_q)
          frame_d = (frame_q == FW'(CS_LEN - 1)) ? '0 : frame_q + 1'b1;
      end else begin
        cell_d = cell_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_q  <= '0;
      right_q <= 1'b0;
      frame_q <= '0;
      word_q  <= '0;
      ref_q   <= 1'b0;
      line_q  <= 1'b0;
      rsmp_q  <= '0;
      pre_q   <= PRE_B;
    end else begin
      cell_q  <= cell_d;
      right_q <= right_d;
      frame_q <= frame_d;
      word_q  <= word_d;
      ref_q   <= ref_d;
      line_q  <= line_d;
      rsmp_q  <= rsmp_d;
      pre_q   <= pre_d;
    end
  end

  assign line      = line_q;
  assign frame_idx = frame_q;

  // R2
  bit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_en && int'(cell_q) >= PRE_CELLS && !cell_q[0] |=> line_q != $past(line_q));
  // R1
  frame_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_en && cell_q == CW'(CELLS_PER_SF - 1) |=> line_q == ref_q);
  // R3
  frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(frame_q) < CS_LEN);

endmodule

// File: rtl/spdif_dr_tx.sv
module spdif_dr_tx import spdif_tx_pkg::*; #(
  parameter  int SAMPLE_W = 20,
  parameter  int NPAIR    = 4,
  parameter  int CS_LEN   = 192,
  localparam int SEL_W    = (NPAIR > 1) ? $clog2(NPAIR) : 1,
  localparam int FW       = $clog2(CS_LEN)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cell_en,
  input  logic                        frame_stb,
  input  logic [NPAIR*2*SAMPLE_W-1:0] link_pairs,
  input  logic [SEL_W-1:0]            pair_sel,
  input  logic                        dbl_rate,
  input  logic [1:0]                  rate_code,
  input  logic                        vld_ctl,
  input  logic                        force_invalid,
  input  logic                        non_pcm,
  input  logic                        pro_use,
  input  logic                        copy_flag,
  input  logic                        pre_emph,
  input  logic [6:0]                  category,
  input  logic                        gen_level,
  input  logic                        ovr_clr,
  output logic                        spdif_out,
  output logic                        overrun
);

  logic                rst_meta_q, rst_sync_n;
  logic [SAMPLE_W-1:0] head_l, head_r;
  logic                head_vld, pop, valid_bit, cs_bit;
  logic [FW-1:0]       frame_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign valid_bit = vld_ctl | force_invalid | (rate_code == 2'b01);

  spdif_pair_buf #(.SAMPLE_W(SAMPLE_W), .NPAIR(NPAIR)) u_buf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (frame_stb),
    .dbl      (dbl_rate),
    .sel      (pair_sel),
    .pair_bus (link_pairs),
    .pop      (pop),
    .ovr_clr  (ovr_clr),
    .head_l   (head_l),
    .head_r   (head_r),
    .head_vld (head_vld),
    .overrun  (overrun)
  );

  spdif_cs_gen #(.CS_LEN(CS_LEN)) u_cs (
    .frame_idx (frame_idx),
    .pro_use   (pro_use),
    .non_pcm   (non_pcm),
    .copy_flag (copy_flag),
    .pre_emph  (pre_emph),
    .category  (category),
    .gen_level (gen_level),
    .dbl_rate  (dbl_rate),
    .rate_code (rate_code),
    .cs_bit    (cs_bit)
  );

  spdif_bmc_ser #(.SAMPLE_W(SAMPLE_W), .CS_LEN(CS_LEN)) u_ser (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cell_en   (cell_en),
    .head_l    (head_l),
    .head_r    (head_r),
    .head_vld  (head_vld),
    .valid_bit (valid_bit),
    .cs_bit    (cs_bit),
    .pop       (pop),
    .frame_idx (frame_idx),
    .line      (spdif_out)
  );

  // R12
  rst_quiet_chk: assert property (@(posedge clk) !rst_sync_n |-> !spdif_out && !overrun);

endmodule

// File: tb/spdif_dr_tx_test.sv
module spdif_dr_tx_test;
  localparam int W   = 20;
  localparam int NP  = 4;
  localparam int CSL = 32;
  localparam int NC  = CSL * 128;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cell_en, frame_stb, dbl_rate, vld_ctl, force_invalid;
  logic non_pcm, pro_use, copy_flag, pre_emph, gen_level, ovr_clr;
  logic [NP*2*W-1:0] link_pairs;
  logic [1:0] pair_sel, rate_code;
  logic [6:0] category;
  logic spdif_out, overrun;

  spdif_dr_tx #(.SAMPLE_W(W), .NPAIR(NP), .CS_LEN(CSL)) uut (
    .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .frame_stb(frame_stb),
    .link_pairs(link_pairs), .pair_sel(pair_sel), .dbl_rate(dbl_rate),
    .rate_code(rate_code), .vld_ctl(vld_ctl), .force_invalid(force_invalid),
    .non_pcm(non_pcm), .pro_use(pro_use), .copy_flag(copy_flag),
    .pre_emph(pre_emph), .category(category), .gen_level(gen_level),
    .ovr_clr(ovr_clr), .spdif_out(spdif_out), .overrun(overrun));

  int checks = 0;
  int errors = 0;
  logic [2*W-1:0] expq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] smp(int k, int p, int lr);
    return 20'h80000 | 20'((k * 131 + p * 17 + lr * 7 + 3) & 20'h7FFFF);
  endfunction

  function automatic logic [31:0] exp_cs();
    logic [31:0] w = '0;
    w[0] = pro_use; w[1] = non_pcm; w[2] = ~copy_flag; w[3] = pre_emph;
    w[14:8] = category; w[15] = gen_level;
    case (rate_code)
      2'b00: w[27] = dbl_rate;
      2'b10: begin w[25] = 1'b1; w[27] = dbl_rate; end
      2'b11: begin w[24] = 1'b1; w[25] = 1'b1; w[27] = dbl_rate; end
      default: w[24] = 1'b1;
    endcase
    return w;
  endfunction

  task automatic run_cfg(input int i, input bit ovr_mode);
    bit cells[64];
    bit refl = 1'b0;
    int fidx = 0;
    int nstb = 0;
    logic [31:0] csw = '0;
    logic [W-1:0] lsmp = '0;
    bit lcs = 1'b0;
    bit found = 1'b0;
    logic [3:0] iv = 4'(i);
    expq.delete();
    rst_n = 1'b0; frame_stb = 1'b0; ovr_clr = 1'b0; cell_en = 1'b1;
    dbl_rate = iv[0]; rate_code = iv[2:1]; pair_sel = iv[3:2];
    pro_use = iv[3]; non_pcm = iv[1] ^ iv[3]; copy_flag = iv[2];
    pre_emph = iv[0] ^ iv[1]; category = 7'((i * 23 + 5) & 7'h7F);
    gen_level = iv[3] ^ iv[0]; vld_ctl = (i == 6 || i == 9);
    force_invalid = (i % 5 == 2);
    link_pairs = '0;
    repeat (3) @(negedge clk);
    // R12
    chk(spdif_out == 1'b0 && overrun == 1'b0, "R12", "in reset", {spdif_out, overrun}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R12
    chk(spdif_out == 1'b0 && overrun == 1'b0, "R12", "after release", {spdif_out, overrun}, 0);
    for (int t = 0; t < 8 && !found; t++) begin
      @(negedge clk);
      if (spdif_out) found = 1'b1;
    end
    // R3
    chk(found, "R3", "stream start", found, 1);
    for (int c = 0; c < NC; c++) begin
      if (c > 0) @(negedge clk);
      cells[c % 64] = spdif_out;
      frame_stb = 1'b0;
      ovr_clr = 1'b0;
      if ((!ovr_mode && ((dbl_rate && c % 256 == 10) || (!dbl_rate && c % 128 == 10))) ||
          (ovr_mode && (c == 10 || c == 15))) begin
        frame_stb = 1'b1;
        for (int p = 0; p < NP; p++)
          link_pairs[p*2*W +: 2*W] = {smp(nstb, p, 1), smp(nstb, p, 0)};
        if (ovr_mode) expq.delete();
        if (dbl_rate) expq.push_back({smp(nstb, 0, 1), smp(nstb, 0, 0)});
        expq.push_back({smp(nstb, int'(pair_sel), 1), smp(nstb, int'(pair_sel), 0)});
        nstb++;
      end
      if (ovr_mode) begin
        // R8
        if (c == 9)   chk(overrun == 1'b0, "R8", "before overrun", overrun, 0);
        if (c == 16)  chk(overrun == 1'b1, "R8", "overrun set", overrun, 1);
        if (c == 99)  chk(overrun == 1'b1, "R8", "overrun sticky", overrun, 1);
        if (c == 100) ovr_clr = 1'b1;
        if (c == 101) chk(overrun == 1'b0, "R8", "overrun cleared", overrun, 0);
      end
      if (c % 64 == 63) begin
        bit right = ((c / 64) % 2) == 1;
        logic [7:0] pat, pexp;
        logic [31:0] w = '0;
        bit edges_ok = 1'b1;
        bit vexp;
        for (int j = 0; j < 8; j++) pat[7-j] = cells[j] ^ refl;
        pexp = right ? 8'b1110_0100 : (fidx == 0 ? 8'b1110_1000 : 8'b1110_0010);
        // R2 R3 preamble shape and order
        chk(pat == pexp, "R3", "preamble", pat, pexp);
        for (int b = 4; b < 32; b++) begin
          if (cells[2*b] == cells[2*b-1]) edges_ok = 1'b0;
          w[b] = cells[2*b] ^ cells[2*b+1];
        end
        // R2
        chk(edges_ok, "R2", "bit-start transitions", edges_ok, 1);
        // R1
        chk(w[7:4] == 4'h0 && w[29] == 1'b0, "R1", "aux/user zero", {w[29], w[7:4]}, 0);
        chk(^w[31:4] == 1'b0, "R1", "even parity", w, 0);
        vexp = vld_ctl | force_invalid | (rate_code == 2'b01);
        // R4
        chk(w[28] == vexp, "R4", "validity", w[28], vexp);
        if (!right) begin
          lsmp = w[27:8];
          lcs = w[30];
        end else begin
          // R9
          chk(w[30] == lcs, "R9", "cs equal in both subframes", w[30], lcs);
          csw[fidx] = lcs;
          if (lsmp == '0 && w[27:8] == '0) begin
            if (fidx == 0 && !ovr_mode) checks++;
          end else if (expq.size() == 0) begin
            chk(1'b0, dbl_rate ? "R6" : "R5", "unexpected sample", {w[27:8], lsmp}, 0);
          end else begin
            logic [2*W-1:0] e = expq.pop_front();
            chk({w[27:8], lsmp} == e, dbl_rate ? "R6" : "R5", "sample pair",
                {w[27:8], lsmp}, e);
          end
          // R7 first frame after reset carries zeros
          if (fidx == 0)
            chk(lsmp == '0 && w[27:8] == '0, "R7", "empty frame zeros", {w[27:8], lsmp}, 0);
          fidx++;
          if (fidx == CSL) begin
            logic [31:0] ec = exp_cs();
            chk({csw[23:0], csw[31:28]} == {ec[23:0], ec[31:28]}, "R9", "cs fields",
                csw, ec);
            chk(csw[27:24] == ec[27:24], (rate_code == 2'b01) ? "R11" : "R10",
                "rate field", csw[27:24], ec[27:24]);
            fidx = 0;
          end
        end
        refl = cells[63];
      end
    end
    // R8 no false overrun at matched cadence
    if (!ovr_mode) chk(overrun == 1'b0, "R8", "no overrun at cadence", overrun, 0);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) run_cfg(i, 1'b0);
    run_cfg(13, 1'b1);
    report();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

endmodule